// File: doc/BRIEF.md
# Composite Sync Vertical Sync Separator

This block recovers a clean vertical sync from a composite sync stream. It measures each active pulse by its width. Short pulses are dropped: line syncs, equalization pulses and serration pulses never reach the output. Pulses that outlast a programmable threshold are let through as vertical sync.

The threshold is given in fixed units of `TICKS_PER_UNIT` system clocks. With the default 8 clocks and a 40 MHz system clock, one unit is 200 ns, so a threshold value of 5 gives 1 µs. A prescaler turns clock cycles into units, and a saturating unit counter feeds a comparator. Both restart whenever the measured level goes inactive.

Because the block has to wait out the threshold before it can decide, the recovered vertical sync starts exactly one threshold after the synchronized pulse begins. It ends on the same cycle as that pulse, so it is shorter than the pulse by the threshold. A polarity input selects whether high or low levels on the input count as active.

Top module: `csync_vsep`

## Requirements
- R1: While `rstN` is low, `vsyncOut` is 0, whatever `syncIn`, `activeHigh` and `thresh` are.
- R2: With `thresh` = N ≥ 1, an active pulse lasting at most 8·N clock cycles never drives `vsyncOut` high.
- R3: With `thresh` = N, an active pulse lasting L > 8·N cycles raises `vsyncOut` exactly 3 + 8·N clock edges after the first edge that samples the active level. The 3 edges are two synchronizer flops and one level register.
- R4: `vsyncOut` falls 3 edges after the input returns inactive, on the same cycle the synchronized level does. A passed pulse is therefore high for L − 8·N cycles.
- R5: `thresh` = 0 disables rejection: `vsyncOut` follows the synchronized active level, 3 edges late and with the same width.
- R6: `activeHigh` = 1 measures high pulses and `activeHigh` = 0 measures low pulses. A long stretch at the inactive level never produces output.
- R7: The unit counter saturates at 2^8 − 1. A pulse longer than 256 units keeps `vsyncOut` high until the pulse ends, even with `thresh` = 255.
- R8: Every pulse is measured from zero. After a rejected pulse, a single inactive cycle clears the measurement, and the next pulse again needs the full 8·N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (40 MHz nominal) |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Asynchronous composite sync level |
| activeHigh | input | 1 | 1: high level is active; 0: low level is active |
| thresh | input | THRESH_W | Rejection threshold in units of TICKS_PER_UNIT clocks |
| vsyncOut | output | 1 | Recovered vertical sync, active high |

## Verification
On every cycle, the assertions check the following against an independent model of the synchronized level and its run length:
- the output is quiet during reset;
- it is never high while the delayed input is inactive;
- it never rises before the run length reaches eight clocks per threshold unit, and rises exactly at that point;
- once high, it stays high for as long as the pulse lasts.

Only the bench's scenarios can show three things: that complete pulses of every length around the boundary are decided correctly for both polarities, that a one-cycle gap truly resets the measurement, and that a pulse far beyond the counter range survives saturation with the exact expected width.

// File: rtl/csync_vsep_pkg.sv
package csync_vsep_pkg;

  // Strobes from the control half to the measuring datapath
  typedef struct packed {
    logic clearAll;  // level inactive: restart prescaler and unit count
    logic advance;   // level active: keep measuring
  } dpStrobe_t;

endpackage

// File: rtl/csync_vsep_sync.sv
module csync_vsep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[gi] <= 1'b0;
          else       chain[gi] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[gi] <= 1'b0;
          else       chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/csync_vsep_ctrl.sv
module csync_vsep_ctrl
  import csync_vsep_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       activeHigh,
  input  logic       reached,
  output dpStrobe_t  strobe,
  output logic       vsyncOut
);
  logic syncedRaw;
  logic activeQ;

  csync_vsep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (syncIn),
    .dout (syncedRaw)
  );

  // Polarity-corrected level, registered so that reset forces it inactive
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) activeQ <= 1'b0;
    else       activeQ <= activeHigh ? syncedRaw : ~syncedRaw;
  end

  always_comb begin
    strobe.clearAll = ~activeQ;
    strobe.advance  = activeQ;
  end

  assign vsyncOut = activeQ & reached;
endmodule

// File: rtl/csync_vsep_dp.sv
module csync_vsep_dp
  import csync_vsep_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 8,
  parameter int THRESH_W       = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [THRESH_W-1:0] thresh,
  output logic                reached
);
  localparam logic [THRESH_W-1:0] UNIT_MAX = {THRESH_W{1'b1}};

  logic                unitTick;
  logic [THRESH_W-1:0] units;

  generate
    if (TICKS_PER_UNIT > 1) begin : g_prescale
      localparam int PRE_W = $clog2(TICKS_PER_UNIT);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_UNIT - 1);
      logic [PRE_W-1:0] pre;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                pre <= '0;
        else if (strobe.clearAll) pre <= '0;
        else if (strobe.advance)  pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      end

      assign unitTick = strobe.advance && (pre == PRE_LAST);
    end else begin : g_noscale
      assign unitTick = strobe.advance;
    end
  endgenerate

  // Saturating unit counter: very long pulses stay past any threshold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               units <= '0;
    else if (strobe.clearAll)                units <= '0;
    else if (unitTick && (units != UNIT_MAX)) units <= units + 1'b1;
  end

  assign reached = (units >= thresh);
endmodule

// File: rtl/csync_vsep.sv
module csync_vsep
  import csync_vsep_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 8,
  parameter int THRESH_W       = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                syncIn,
  input  logic                activeHigh,
  input  logic [THRESH_W-1:0] thresh,
  output logic                vsyncOut
);
  dpStrobe_t strobe;
  logic      reached;

  csync_vsep_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .activeHigh (activeHigh),
    .reached    (reached),
    .strobe     (strobe),
    .vsyncOut   (vsyncOut)
  );

  csync_vsep_dp #(
    .TICKS_PER_UNIT (TICKS_PER_UNIT),
    .THRESH_W       (THRESH_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .thresh  (thresh),
    .reached (reached)
  );
endmodule

// File: rtl/csync_vsep_chk.sv
module csync_vsep_chk #(
  parameter int TICKS_PER_UNIT = 8,
  parameter int THRESH_W       = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                syncIn,
  input logic                activeHigh,
  input logic [THRESH_W-1:0] thresh,
  input logic                vsyncOut
);
  // Independent model of the delayed level and its run length
  logic        raw1, raw2, act3;
  logic [15:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      raw1 <= 1'b0; raw2 <= 1'b0; act3 <= 1'b0;
    end else begin
      raw1 <= syncIn;
      raw2 <= raw1;
      act3 <= activeHigh ? raw2 : ~raw2;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 runLen <= '0;
    else if (!act3)            runLen <= '0;
    else if (runLen != 16'hFFFF) runLen <= runLen + 16'd1;
  end

  int needLen;
  assign needLen = int'(thresh) * TICKS_PER_UNIT;

  // R1
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rstN |-> !vsyncOut);

  // R4
  a_r4_low_when_inactive: assert property (@(posedge clk) disable iff (!rstN)
    !act3 |-> !vsyncOut);

  // R2
  a_r2_no_early_pass: assert property (@(posedge clk) disable iff (!rstN)
    (act3 && (int'(runLen) < needLen)) |-> !vsyncOut);

  // R3
  a_r3_rise_at_threshold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vsyncOut) |-> (int'(runLen) == needLen));

  // R7
  a_r7_hold_while_active: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncOut && $stable(thresh)) |=> (vsyncOut || !act3));
endmodule

bind csync_vsep csync_vsep_chk #(
  .TICKS_PER_UNIT (TICKS_PER_UNIT),
  .THRESH_W       (THRESH_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .syncIn     (syncIn),
  .activeHigh (activeHigh),
  .thresh     (thresh),
  .vsyncOut   (vsyncOut)
);

// File: tb/csync_vsep_bench.sv
module csync_vsep_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 8;
  localparam int LAT        = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncIn = 1'b0;
  logic       activeHigh = 1'b1;
  logic [7:0] thresh = 8'd0;
  logic       vsyncOut;

  int tests = 0;
  int fails = 0;
  int cycleCnt = 0;
  int highCnt = 0;
  int riseAt = -1;
  logic prevOut = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csync_vsep u_csync_vsep (
    .clk        (clk),
    .rstN       (rstN),
    .syncIn     (syncIn),
    .activeHigh (activeHigh),
    .thresh     (thresh),
    .vsyncOut   (vsyncOut)
  );

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    cycleCnt = cycleCnt + 1;
    if (vsyncOut) highCnt = highCnt + 1;
    if (vsyncOut && !prevOut) riseAt = cycleCnt;
    prevOut = vsyncOut;
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // One pulse of L active cycles followed by tail inactive cycles
  task automatic pulse(input string req, input int n, input int len, input int tail);
    int startC, startH, expHigh, expRise;
    step();
    startC = cycleCnt;
    startH = highCnt;
    riseAt = -1;
    syncIn = activeHigh;
    repeat (len) step();
    syncIn = ~activeHigh;
    repeat (tail) step();
    expHigh = (len > TICKS * n) ? len - TICKS * n : 0;
    check(req, highCnt - startH, expHigh, $sformatf("high cycles N=%0d L=%0d", n, len));
    if (expHigh > 0) begin
      expRise = LAT + TICKS * n;
      check(req, riseAt - startC, expRise, $sformatf("rise offset N=%0d L=%0d", n, len));
    end
  endtask

  task automatic setPol(input logic pol);
    activeHigh = pol;
    syncIn = ~pol;
    repeat (8) step();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    int startH;
    // R1: active input during reset, bypass threshold
    activeHigh = 1'b1;
    thresh = 8'd0;
    syncIn = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", int'(vsyncOut), 0, "output during reset");
    syncIn = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    rstN = 1'b1;
    repeat (4) step();
    check("R1", int'(vsyncOut), 0, "output after reset");

    // R5: bypass with threshold zero, both polarities
    for (int p = 1; p >= 0; p--) begin
      setPol(p[0]);
      thresh = 8'd0;
      for (int len = 1; len <= 6; len++) pulse("R5", 0, len, 6);
    end

    // R2 R3 R4 R6: sweep lengths around each threshold, both polarities
    for (int p = 1; p >= 0; p--) begin
      setPol(p[0]);
      for (int n = 1; n <= 5; n++) begin
        if (n == 4) continue;
        thresh = 8'(n);
        for (int len = 1; len <= TICKS * n + 6; len++)
          pulse((len > TICKS * n) ? "R3" : "R2", n, len, 6);
        pulse("R4", n, TICKS * n + 1, 6);
      end
    end

    // R6: long stretch at inactive level gives nothing
    for (int p = 1; p >= 0; p--) begin
      setPol(p[0]);
      thresh = 8'd1;
      startH = highCnt;
      syncIn = ~activeHigh;
      repeat (200) step();
      check("R6", highCnt - startH, 0, $sformatf("inactive stretch pol=%0d", p));
    end

    // R8: rejected pulse, one-cycle gap, then the next pulse measured afresh
    setPol(1'b1);
    for (int n = 1; n <= 3; n++) begin
      thresh = 8'(n);
      pulse("R8", n, TICKS * n, 1);
      pulse("R8", n, TICKS * n, 1);
      pulse("R8", n, TICKS * n + 4, 6);
    end

    // R7: pulses beyond the counter range, maximal threshold
    thresh = 8'd255;
    pulse("R7", 255, TICKS * 255, 6);
    pulse("R7", 255, TICKS * 256 + 100, 6);
    thresh = 8'd200;
    pulse("R7", 200, TICKS * 300, 6);
    setPol(1'b0);
    thresh = 8'd255;
    pulse("R7", 255, TICKS * 260, 6);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule